// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers of a message signaled interrupt capability and presents them to the rest of an endpoint. Configuration reads and writes arrive as a dword index relative to the capability base, with a 32-bit write word and four byte enables. The first dword carries a fixed capability identifier (05h), a next-capability pointer and the 16-bit message control word. The following dwords carry the message address, an optional upper address and a 16-bit message data value.

The layout after the lower address depends on the `ADDR64` parameter. With 64-bit addressing, the upper address sits at base+8h and the data at base+Ch. Without it, the data moves to base+8h and base+Ch reads as zero. The block hands the enable bit, the granted vector count, the full 64-bit message address and the data value to a separate message generator. When MSI is enabled, it also masks the legacy interrupt request.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword index 0 reads as {control word in bits 31:16, `NEXT_PTR` in bits 15:8, 8'h05 in bits 7:0}. The identifier and pointer ignore writes.
- R2: Control word bit 0 is the MSI enable, writable through byte enable 2. Bits 6:4 are the requested-vector field, written in the same way. Bits 3:1 always read `MMC_CAP`, bit 7 always reads `ADDR64`, and bits 15:8 read 0. Writes to these fixed bits have no effect.
- R3: Dword index 1 is the lower message address. Bits 1:0 always read 0 and ignore writes. `msi_addr[31:0]` shows the same value.
- R4: With `ADDR64`=1, dword index 2 is the upper message address, also driven on `msi_addr[63:32]`. Dword index 3 holds the message data.
- R5: With `ADDR64`=0, dword index 2 holds the message data. Dword index 3 reads 0 and ignores writes. `msi_addr[63:32]` stays 0.
- R6: The message data register is 16 bits wide and drives `msi_data`. Bits 31:16 of its dword read 0.
- R7: A write changes only the bytes whose `cfg_be` bit is 1. Bit n of `cfg_be` covers `cfg_wdata` bits 8n+7:8n.
- R8: `msi_vec_cnt` equals 2 to the power of the smaller of the requested-vector field and `MMC_CAP`.
- R9: `intx_out` equals `intx_req` while the enable is 0 and is held at 0 while the enable is 1.
- R10: Reset (`rst_n` low) clears the enable, the requested-vector field, both address halves and the data. This makes `msi_vec_cnt` 1.
- R11: Dword indices of 4 and above read 0, and writes to them change no register.
- R12: A write takes effect at the clock edge on which `cfg_wr` is sampled 1. Reads are combinational from `cfg_dw`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | DW_W | Dword index from capability base |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for `cfg_dw` |
| intx_req | input | 1 | Legacy interrupt request from the function |
| intx_out | output | 1 | Legacy interrupt request after MSI masking |
| msi_en | output | 1 | MSI enable |
| msi_vec_cnt | output | 6 | Number of granted vectors |
| msi_addr | output | 64 | Message address |
| msi_data | output | MSG_DATA_W | Message data |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. The first copy uses `ADDR64`=1, `MMC_CAP`=3 and `DW_W`=3. It exercises the upper address slot and lets the clamp act on requested values 4 to 7. The second copy uses `ADDR64`=0 and `MMC_CAP`=1. It exercises the moved data slot, the dead dword at Ch and a clamp that acts on almost any request. With a 3-bit dword index, both copies also reach the empty offsets above Ch.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  // dword slots inside the capability window
  localparam logic [1:0] SLOT_HEAD    = 2'd0;
  localparam logic [1:0] SLOT_ADDR_LO = 2'd1;
  localparam logic [1:0] SLOT_SECOND  = 2'd2;
  localparam logic [1:0] SLOT_THIRD   = 2'd3;

  // where the data word lives for a given addressing mode
  function automatic logic [1:0] data_slot(input bit wide);
    return wide ? SLOT_THIRD : SLOT_SECOND;
  endfunction

  // granted exponent: request limited by capability
  function automatic logic [2:0] grant_exp(input logic [2:0] req, input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // vector count from granted exponent
  function automatic logic [5:0] vec_count(input logic [2:0] e);
    return 6'd1 << e;
  endfunction

  // per-byte merge of a write into an existing word
  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/msi_cfg_decode.sv
module msi_cfg_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned DW_W   = 3,
  parameter bit          ADDR64 = 1'b1
) (
  input  logic [DW_W-1:0] cfg_dw,
  input  logic            cfg_wr,
  output logic            hit_head,
  output logic            hit_addr_lo,
  output logic            hit_addr_hi,
  output logic            hit_data,
  output logic            wr_head,
  output logic            wr_addr_lo,
  output logic            wr_addr_hi,
  output logic            wr_data
);

  logic       in_win;
  logic [1:0] slot;

  assign slot = cfg_dw[1:0];

  generate
    if (DW_W > 2) begin : g_wide_idx
      assign in_win = ~|cfg_dw[DW_W-1:2];
    end else begin : g_narrow_idx
      assign in_win = 1'b1;
    end
  endgenerate

  assign hit_head    = in_win && (slot == SLOT_HEAD);
  assign hit_addr_lo = in_win && (slot == SLOT_ADDR_LO);
  assign hit_addr_hi = in_win && ADDR64 && (slot == SLOT_SECOND);
  assign hit_data    = in_win && (slot == data_slot(ADDR64));

  assign wr_head    = cfg_wr && hit_head;
  assign wr_addr_lo = cfg_wr && hit_addr_lo;
  assign wr_addr_hi = cfg_wr && hit_addr_hi;
  assign wr_data    = cfg_wr && hit_data;

endmodule

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg
  import msi_cap_pkg::*;
#(
  parameter int unsigned MMC_CAP = 3,
  parameter bit          ADDR64  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_enable_bit,
  input  logic [2:0]  wr_req_field,
  output logic        msi_en,
  output logic [15:0] ctrl_word,
  output logic [5:0]  vec_cnt
);

  localparam logic [2:0] CAP_BITS = 3'(MMC_CAP);
  localparam logic       WIDE_BIT = ADDR64;

  logic       en_q;
  logic [2:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 3'd0;
    end else if (wr_en) begin
      en_q  <= wr_enable_bit;
      req_q <= wr_req_field;
    end
  end

  assign msi_en    = en_q;
  assign ctrl_word = {8'h00, WIDE_BIT, req_q, CAP_BITS, en_q};
  assign vec_cnt   = vec_count(grant_exp(req_q, CAP_BITS));

endmodule

// File: rtl/msi_addr_reg.sv
module msi_addr_reg
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [63:0] addr
);

  logic [31:0] lo_q;
  logic [31:0] lo_next;

  // bits 1:0 forced to zero on every write
  assign lo_next = byte_merge(lo_q, wdata, be) & 32'hFFFF_FFFC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= 32'd0;
    else if (wr_lo) lo_q <= lo_next;
  end

  generate
    if (ADDR64) begin : g_upper
      logic [31:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= 32'd0;
        else if (wr_hi) hi_q <= byte_merge(hi_q, wdata, be);
      end
      assign addr = {hi_q, lo_q};
    end else begin : g_no_upper
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign addr = {32'd0, lo_q};
    end
  endgenerate

endmodule

// File: rtl/msi_data_reg.sv
module msi_data_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0] data
);

  localparam int unsigned NB = DATA_W / 8;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               lane_q <= 8'd0;
        else if (wr_en && be[b])  lane_q <= wdata[b*8 +: 8];
      end
      assign data[b*8 +: 8] = lane_q;
    end
  endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter logic [7:0]  NEXT_PTR   = 8'h00,
  parameter bit          ADDR64     = 1'b1,
  parameter int unsigned MMC_CAP    = 3,
  parameter int unsigned DW_W       = 3,
  parameter int unsigned MSG_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [DW_W-1:0]       cfg_dw,
  input  logic [31:0]           cfg_wdata,
  input  logic [3:0]            cfg_be,
  output logic [31:0]           cfg_rdata,
  input  logic                  intx_req,
  output logic                  intx_out,
  output logic                  msi_en,
  output logic [5:0]            msi_vec_cnt,
  output logic [63:0]           msi_addr,
  output logic [MSG_DATA_W-1:0] msi_data
);

  localparam int unsigned DATA_NB = MSG_DATA_W / 8;

  // decode results, also watched by the checker
  logic hit_head, hit_addr_lo, hit_addr_hi, hit_data;
  logic wr_head, wr_addr_lo, wr_addr_hi, wr_data;

  // named write events
  logic ev_ctrl_wr, ev_addr_lo_wr, ev_addr_hi_wr, ev_data_wr;

  logic [15:0] ctrl_word;

  msi_cfg_decode #(.DW_W(DW_W), .ADDR64(ADDR64)) u_dec (
    .cfg_dw      (cfg_dw),
    .cfg_wr      (cfg_wr),
    .hit_head    (hit_head),
    .hit_addr_lo (hit_addr_lo),
    .hit_addr_hi (hit_addr_hi),
    .hit_data    (hit_data),
    .wr_head     (wr_head),
    .wr_addr_lo  (wr_addr_lo),
    .wr_addr_hi  (wr_addr_hi),
    .wr_data     (wr_data)
  );

  // control word lives in byte lane 2 of the head dword
  assign ev_ctrl_wr    = wr_head && cfg_be[2];
  assign ev_addr_lo_wr = wr_addr_lo && |cfg_be;
  assign ev_addr_hi_wr = wr_addr_hi && |cfg_be;
  assign ev_data_wr    = wr_data && |cfg_be[DATA_NB-1:0];

  msi_ctrl_reg #(.MMC_CAP(MMC_CAP), .ADDR64(ADDR64)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (ev_ctrl_wr),
    .wr_enable_bit (cfg_wdata[16]),
    .wr_req_field  (cfg_wdata[22:20]),
    .msi_en        (msi_en),
    .ctrl_word     (ctrl_word),
    .vec_cnt       (msi_vec_cnt)
  );

  msi_addr_reg #(.ADDR64(ADDR64)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (ev_addr_lo_wr),
    .wr_hi (ev_addr_hi_wr),
    .wdata (cfg_wdata),
    .be    (cfg_be),
    .addr  (msi_addr)
  );

  msi_data_reg #(.DATA_W(MSG_DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ev_data_wr),
    .wdata (cfg_wdata[MSG_DATA_W-1:0]),
    .be    (cfg_be[DATA_NB-1:0]),
    .data  (msi_data)
  );

  always_comb begin
    cfg_rdata = 32'd0;
    if (hit_head)    cfg_rdata = {ctrl_word, NEXT_PTR, MSI_CAP_ID};
    if (hit_addr_lo) cfg_rdata = msi_addr[31:0];
    if (hit_addr_hi) cfg_rdata = msi_addr[63:32];
    if (hit_data)    cfg_rdata = 32'(msi_data);
  end

  // legacy request blocked while messages are enabled
  assign intx_out = intx_req && !msi_en;

endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int unsigned MMC_CAP    = 3,
  parameter bit          ADDR64     = 1'b1,
  parameter int unsigned MSG_DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msi_en,
  input logic                  intx_req,
  input logic                  intx_out,
  input logic [63:0]           msi_addr,
  input logic [5:0]            msi_vec_cnt,
  input logic [MSG_DATA_W-1:0] msi_data,
  input logic [31:0]           cfg_rdata,
  input logic                  hit_data,
  input logic                  ev_ctrl_wr,
  input logic                  ev_addr_hi_wr,
  input logic                  ev_data_wr
);

  // R9
  intx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !intx_out);

  // R9
  intx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en && intx_req) |-> intx_out);

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_addr[1:0] == 2'b00);

  // R8
  vec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(msi_vec_cnt) == 1) && (msi_vec_cnt <= 6'(1 << MMC_CAP)));

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ctrl_wr |=> $stable(msi_en));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_data_wr |=> $stable(msi_data));

  // R6
  data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |-> (cfg_rdata[31:MSG_DATA_W] == '0));

  generate
    if (!ADDR64) begin : g_narrow
      // R5
      hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_addr[63:32] == 32'd0);
    end else begin : g_wide
      // R4
      hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_addr_hi_wr |=> $stable(msi_addr[63:32]));
    end
  endgenerate

endmodule

bind msi_cap_regs msi_cap_regs_chk #(
  .MMC_CAP(MMC_CAP), .ADDR64(ADDR64), .MSG_DATA_W(MSG_DATA_W)
) u_chk (.*);

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic        en;
    logic [2:0]  req;
    logic [31:0] alo;
    logic [31:0] ahi;
    logic [15:0] dat;
  } mdl_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_dw = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [3:0]  cfg_be = 4'd0;
  logic        intx_req = 1'b0;

  logic [31:0] a_rd, b_rd;
  logic        a_intx, b_intx, a_en, b_en;
  logic [5:0]  a_vec, b_vec;
  logic [63:0] a_addr, b_addr;
  logic [15:0] a_dat, b_dat;

  int total = 0;
  int fails = 0;
  mdl_t ma, mb;

  msi_cap_regs #(.NEXT_PTR(8'h70), .ADDR64(1'b1), .MMC_CAP(3), .DW_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(a_rd),
    .intx_req(intx_req), .intx_out(a_intx), .msi_en(a_en),
    .msi_vec_cnt(a_vec), .msi_addr(a_addr), .msi_data(a_dat));

  msi_cap_regs #(.NEXT_PTR(8'h00), .ADDR64(1'b0), .MMC_CAP(1), .DW_W(3)) uut_b (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(b_rd),
    .intx_req(intx_req), .intx_out(b_intx), .msi_en(b_en),
    .msi_vec_cnt(b_vec), .msi_addr(b_addr), .msi_data(b_dat));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] keep, input logic [31:0] w,
                                        input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (w & m) | (keep & ~m);
  endfunction

  function automatic mdl_t apply(input mdl_t m, input bit wide, input logic [2:0] dw,
                                 input logic [31:0] w, input logic [3:0] be);
    logic [31:0] t;
    mdl_t r = m;
    t = lanes({16'h0, m.dat}, w, be);
    if (dw == 3'd0 && be[2]) begin
      r.en  = w[16];
      r.req = w[22:20];
    end
    if (dw == 3'd1) r.alo = {lanes(m.alo, w, be)[31:2], 2'b00};
    if (dw == 3'd2 && wide)  r.ahi = lanes(m.ahi, w, be);
    if (dw == 3'd2 && !wide) r.dat = t[15:0];
    if (dw == 3'd3 && wide)  r.dat = t[15:0];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input mdl_t m, input bit wide, input logic [2:0] cap,
                                         input logic [7:0] nxt, input logic [2:0] dw);
    case (dw)
      3'd0: return {8'h00, wide, m.req, cap, m.en, nxt, 8'h05};
      3'd1: return m.alo;
      3'd2: return wide ? m.ahi : {16'h0, m.dat};
      3'd3: return wide ? {16'h0, m.dat} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] exp_vec(input logic [2:0] req, input logic [2:0] cap);
    int n = 1;
    for (int i = 0; i < 7; i++)
      if (i < req && i < cap) n = n * 2;
    return 6'(n);
  endfunction

  task automatic wr(input logic [2:0] dw, input logic [31:0] w, input logic [3:0] be);
    @(negedge clk);
    cfg_dw = dw; cfg_wdata = w; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    // R12: effect visible right after the sampling edge
    ma = apply(ma, 1'b1, dw, w, be);
    mb = apply(mb, 1'b0, dw, w, be);
  endtask

  function automatic string rtag(input bit wide, input logic [2:0] dw);
    case (dw)
      3'd0: return "R1 R2";
      3'd1: return "R3 R7";
      3'd2: return wide ? "R4" : "R5 R6";
      3'd3: return wide ? "R4 R6" : "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic verify_all();
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      cfg_dw = 3'(d);
      #1;
      check({rtag(1'b1, 3'(d)), " wide"}, 64'(a_rd), 64'(exp_rd(ma, 1'b1, 3'd3, 8'h70, 3'(d))));
      check({rtag(1'b0, 3'(d)), " narrow"}, 64'(b_rd), 64'(exp_rd(mb, 1'b0, 3'd1, 8'h00, 3'(d))));
    end
    check("R2 en wide", 64'(a_en), 64'(ma.en));
    check("R2 en narrow", 64'(b_en), 64'(mb.en));
    check("R8 vec wide", 64'(a_vec), 64'(exp_vec(ma.req, 3'd3)));
    check("R8 vec narrow", 64'(b_vec), 64'(exp_vec(mb.req, 3'd1)));
    check("R4 addr wide", a_addr, {ma.ahi, ma.alo});
    check("R5 addr narrow", b_addr, {32'h0, mb.alo});
    check("R6 data wide", 64'(a_dat), 64'(ma.dat));
    check("R6 data narrow", 64'(b_dat), 64'(mb.dat));
    intx_req = 1'b1; #1;
    check("R9 intx wide", 64'(a_intx), 64'(!ma.en));
    check("R9 intx narrow", 64'(b_intx), 64'(!mb.en));
    intx_req = 1'b0; #1;
    check("R9 intx idle", 64'({a_intx, b_intx}), 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ma = '0; mb = '0;
    @(negedge clk); #1;
    check("R10 en", 64'({a_en, b_en}), 64'd0);
    check("R10 addr", a_addr | b_addr, 64'd0);
    check("R10 data", 64'({a_dat, b_dat}), 64'd0);
    check("R10 vec", 64'({a_vec, b_vec}), {52'd0, 6'd1, 6'd1});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run hung, all requirements unchecked got 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    ma = '0; mb = '0;
    do_reset();
    verify_all();

    // R2: fixed fields survive an all-ones write; R8 clamp at request 7
    wr(3'd0, 32'hFFFF_FFFF, 4'hF);
    verify_all();
    // R9: enable then clear
    wr(3'd0, 32'h0000_0000, 4'hF);
    verify_all();
    // R2: byte lane 2 absent, control untouched
    wr(3'd0, 32'h0071_0000, 4'b1011);
    verify_all();
    // R3 low bits; R7 single byte lane
    wr(3'd1, 32'hFFFF_FFFF, 4'hF);
    wr(3'd1, 32'hA5A5_A5A5, 4'b0010);
    verify_all();
    // R4/R5 second and third slots, R6 upper half
    wr(3'd2, 32'h1234_5678, 4'hF);
    wr(3'd3, 32'hDEAD_BEEF, 4'hF);
    verify_all();
    // R11 outside window
    for (int d = 4; d < 8; d++) wr(3'(d), 32'hFFFF_FFFF, 4'hF);
    verify_all();
    // R8 requests across the range
    for (int q = 0; q < 8; q++) begin
      wr(3'd0, {9'd0, 3'(q), 3'd0, 1'b1, 16'd0}, 4'b0100);
      verify_all();
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      wr(3'($urandom % 8), $urandom, 4'($urandom % 16));
      verify_all();
    end

    // R10 reset in mid-run after registers were loaded
    wr(3'd1, 32'hCAFE_F00C, 4'hF);
    wr(3'd0, 32'h0031_0000, 4'h4);
    do_reset();
    verify_all();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule